// File: doc/BRIEF.md
# Two-Level Interrupt Router with Fast-Class Selection

This block gathers 64 level-sensitive peripheral request lines and delivers them to a four-core cluster. The first stage holds an enable bit and a class bit for every line. Each line that is raised and enabled becomes pending. Every pending line belongs to one of two classes, the normal class (IRQ) or the fast class (FIQ). The pending lines then reduce to one shared IRQ signal and one shared FIQ signal.

The second stage sends the shared IRQ signal to one programmable core and the shared FIQ signal to another. Each class has its own 2-bit target field, and no other core sees that shared request. Each core also has two local request lines. These lines raise only that core's IRQ output and ignore the target fields.

Software reaches the block through a single-cycle word register port. Through it, a common handler reads the pending state, the lowest-numbered pending line of each class, and what each core is being interrupted for.

Top module: `irq_casc_router`

## Requirements
- R1: After synchronous reset, all enable bits read 0, all class bits read 0 (every line is IRQ class), the target register reads 0 (both classes aimed at core 0), and every core output is low.
- R2: Line n is pending only while line_i[n] is high and its enable bit is set. Enable bits sit at address 0 (lines 0-31) and address 1 (lines 32-63), with bit n%32 belonging to line n. Pending bits read back at addresses 4 and 5 with the same layout. A raised line whose enable bit is clear leaves the pending bits and the core outputs unchanged.
- R3: Requests are level-sensitive. Dropping a line clears its pending bit, and the outputs that line drove fall one cycle later.
- R4: Class bits sit at addresses 2 and 3, laid out like the enable bits, where 1 selects FIQ and 0 selects IRQ. The shared IRQ signal is the OR of the pending IRQ-class lines, and the shared FIQ signal is the OR of the pending FIQ-class lines.
- R5: The shared IRQ signal reaches only core_irq_o[k], where k is the target register (address 8) bits [1:0].
- R6: The shared FIQ signal reaches only core_fiq_o[k], where k is target register bits [9:8]. This field is independent of the IRQ field.
- R7: The local lines of core c, local_i[2c+1:2c], drive only core_irq_o[c], whatever the target register holds.
- R8: Address 6 gives the IRQ-class source and address 7 gives the FIQ-class source. Each reads as bit 31 = valid and bits [5:0] = lowest-numbered pending line of that class. The register reads 0 when that class has nothing pending.
- R9: A register write becomes effective in the cycle after the write. Each core output is registered, so it follows its inputs with one cycle of latency. rd_data shows the register selected by addr one cycle after addr is presented.
- R10: Address 9+c reads core c's status as follows: bit 0 = shared IRQ aimed here and active, bit 1 = shared FIQ aimed here and active, bits [3:2] = that core's local lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 64 | Peripheral request lines, level, active high |
| local_i | input | 8 | Core-local request lines, two per core |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data for addr |
| core_irq_o | output | 4 | Per-core normal interrupt |
| core_fiq_o | output | 4 | Per-core fast interrupt |

## Verification
The assertions assume that reset is held for at least one clock before the first request is raised. They also assume that request lines and register writes change only between clock edges and hold steady across each edge. The bench drives every input on the falling edge and keeps reset high for several cycles. It changes lines and target fields only while the outputs they affect are being watched on the next falling edge. Every scenario uses distinct line indices on both 32-bit words, so the lowest-index rule is exercised across the word boundary.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
  typedef enum logic [1:0] {WK_NONE, WK_EN, WK_CLS, WK_ROUTE} wr_kind_e;
  localparam int FIQ_ROUTE_LSB = 8;
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_casc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = NUM_LINES / DATA_W,
  parameter int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter int ID_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_i,
  input  wr_kind_e             wr_kind,
  input  logic [WORD_W-1:0]    wr_word,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] cls_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 irq_o,
  output logic                 fiq_o,
  output logic                 irq_vld_o,
  output logic [ID_W-1:0]      irq_id_o,
  output logic                 fiq_vld_o,
  output logic [ID_W-1:0]      fiq_id_o
);
  logic [NUM_LINES-1:0] en_q, cls_q, irq_pend, fiq_pend;

  function automatic logic [ID_W:0] lowest(input logic [NUM_LINES-1:0] v);
    logic [ID_W:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, ID_W'(i)};
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      cls_q <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (wr_kind == WK_EN && wr_word == WORD_W'(w))
          en_q[w*DATA_W +: DATA_W] <= wr_data;
        if (wr_kind == WK_CLS && wr_word == WORD_W'(w))
          cls_q[w*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

  always_comb begin
    pend_o   = line_i & en_q;
    irq_pend = pend_o & ~cls_q;
    fiq_pend = pend_o & cls_q;
    irq_o    = |irq_pend;
    fiq_o    = |fiq_pend;
    {irq_vld_o, irq_id_o} = lowest(irq_pend);
    {fiq_vld_o, fiq_id_o} = lowest(fiq_pend);
  end

  assign en_o  = en_q;
  assign cls_o = cls_q;

  assert_irq_id_src_R8: assert property (@(posedge clk) disable iff (rst)
    irq_vld_o |-> (pend_o[irq_id_o] && !cls_q[irq_id_o]));
  assert_irq_id_lowest_R8: assert property (@(posedge clk) disable iff (rst)
    irq_vld_o |-> ((irq_pend & ~({NUM_LINES{1'b1}} << irq_id_o)) == '0));
  assert_fiq_id_src_R8: assert property (@(posedge clk) disable iff (rst)
    fiq_vld_o |-> (pend_o[fiq_id_o] && cls_q[fiq_id_o]));
  assert_class_split_R4: assert property (@(posedge clk) disable iff (rst)
    !(irq_vld_o && fiq_vld_o && irq_id_o == fiq_id_o));
endmodule

// File: rtl/irq_core_steer.sv
module irq_core_steer #(
  parameter int NUM_CORES = 4,
  parameter int LOCAL_W   = 2,
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int PW        = 2 + LOCAL_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         irq_in,
  input  logic                         fiq_in,
  input  logic [NUM_CORES*LOCAL_W-1:0] local_i,
  input  logic                         route_we,
  input  logic [CORE_W-1:0]            route_irq_d,
  input  logic [CORE_W-1:0]            route_fiq_d,
  output logic [CORE_W-1:0]            route_irq_o,
  output logic [CORE_W-1:0]            route_fiq_o,
  output logic [NUM_CORES*PW-1:0]      core_pend_o,
  output logic [NUM_CORES-1:0]         core_irq_o,
  output logic [NUM_CORES-1:0]         core_fiq_o
);
  logic [CORE_W-1:0]    route_irq_q, route_fiq_q;
  logic [NUM_CORES-1:0] irq_next, fiq_next;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      fiq_next[c] = fiq_in && (route_fiq_q == CORE_W'(c));
      irq_next[c] = (irq_in && (route_irq_q == CORE_W'(c)))
                    || (|local_i[c*LOCAL_W +: LOCAL_W]);
      core_pend_o[c*PW +: PW] = {local_i[c*LOCAL_W +: LOCAL_W], fiq_next[c],
                                 irq_in && (route_irq_q == CORE_W'(c))};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_irq_q <= '0;
      route_fiq_q <= '0;
      core_irq_o  <= '0;
      core_fiq_o  <= '0;
    end else begin
      if (route_we) begin
        route_irq_q <= route_irq_d;
        route_fiq_q <= route_fiq_d;
      end
      core_irq_o <= irq_next;
      core_fiq_o <= fiq_next;
    end
  end

  assign route_irq_o = route_irq_q;
  assign route_fiq_o = route_fiq_q;

  assert_irq_deliver_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irq_in)) |-> core_irq_o[$past(route_irq_q)]);
  assert_fiq_deliver_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fiq_in)) |-> core_fiq_o[$past(route_fiq_q)]);
  assert_fiq_single_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_fiq_o));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_quiet
    assert_core_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(irq_in) && !(|$past(local_i[c*LOCAL_W +: LOCAL_W])))
      |-> !core_irq_o[c]);
  end
endmodule

// File: rtl/irq_casc_router.sv
module irq_casc_router
  import irq_casc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CORES = 4,
  parameter int LOCAL_W   = 2,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LINES-1:0]         line_i,
  input  logic [NUM_CORES*LOCAL_W-1:0] local_i,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_CORES-1:0]         core_irq_o,
  output logic [NUM_CORES-1:0]         core_fiq_o
);
  localparam int NUM_WORDS = NUM_LINES / DATA_W;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int ID_W      = $clog2(NUM_LINES);
  localparam int CORE_W    = $clog2(NUM_CORES);
  localparam int PW        = 2 + LOCAL_W;
  localparam int A_EN      = 0;
  localparam int A_CLS     = NUM_WORDS;
  localparam int A_PEND    = 2 * NUM_WORDS;
  localparam int A_IRQID   = 3 * NUM_WORDS;
  localparam int A_FIQID   = A_IRQID + 1;
  localparam int A_ROUTE   = A_IRQID + 2;
  localparam int A_CORE    = A_IRQID + 3;

  wr_kind_e                wr_kind;
  logic [WORD_W-1:0]       wr_word;
  logic [NUM_LINES-1:0]    en, cls, pend;
  logic                    irq_sh, fiq_sh, irq_vld, fiq_vld;
  logic [ID_W-1:0]         irq_id, fiq_id;
  logic [CORE_W-1:0]       route_irq, route_fiq;
  logic [NUM_CORES*PW-1:0] core_pend;
  logic [DATA_W-1:0]       rd_next;

  always_comb begin
    wr_kind = WK_NONE;
    wr_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wr_en && addr == ADDR_W'(A_EN + w)) begin
        wr_kind = WK_EN;
        wr_word = WORD_W'(w);
      end
      if (wr_en && addr == ADDR_W'(A_CLS + w)) begin
        wr_kind = WK_CLS;
        wr_word = WORD_W'(w);
      end
    end
    if (wr_en && addr == ADDR_W'(A_ROUTE)) wr_kind = WK_ROUTE;
  end

  irq_line_bank #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .line_i(line_i), .wr_kind(wr_kind), .wr_word(wr_word),
    .wr_data(wr_data), .en_o(en), .cls_o(cls), .pend_o(pend),
    .irq_o(irq_sh), .fiq_o(fiq_sh), .irq_vld_o(irq_vld), .irq_id_o(irq_id),
    .fiq_vld_o(fiq_vld), .fiq_id_o(fiq_id));

  irq_core_steer #(.NUM_CORES(NUM_CORES), .LOCAL_W(LOCAL_W)) u_steer (
    .clk(clk), .rst(rst), .irq_in(irq_sh), .fiq_in(fiq_sh), .local_i(local_i),
    .route_we(wr_kind == WK_ROUTE), .route_irq_d(wr_data[CORE_W-1:0]),
    .route_fiq_d(wr_data[FIQ_ROUTE_LSB +: CORE_W]),
    .route_irq_o(route_irq), .route_fiq_o(route_fiq), .core_pend_o(core_pend),
    .core_irq_o(core_irq_o), .core_fiq_o(core_fiq_o));

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(A_EN + w))   rd_next = en[w*DATA_W +: DATA_W];
      if (addr == ADDR_W'(A_CLS + w))  rd_next = cls[w*DATA_W +: DATA_W];
      if (addr == ADDR_W'(A_PEND + w)) rd_next = pend[w*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(A_IRQID)) begin
      rd_next[DATA_W-1] = irq_vld;
      rd_next[ID_W-1:0] = irq_id;
    end
    if (addr == ADDR_W'(A_FIQID)) begin
      rd_next[DATA_W-1] = fiq_vld;
      rd_next[ID_W-1:0] = fiq_id;
    end
    if (addr == ADDR_W'(A_ROUTE)) begin
      rd_next[CORE_W-1:0] = route_irq;
      rd_next[FIQ_ROUTE_LSB +: CORE_W] = route_fiq;
    end
    for (int c = 0; c < NUM_CORES; c++)
      if (addr == ADDR_W'(A_CORE + c)) rd_next[PW-1:0] = core_pend[c*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_route_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == ADDR_W'(A_ROUTE))
    |-> (route_irq == $past(wr_data[CORE_W-1:0])));
endmodule

// File: tb/irq_casc_router_bench.sv
`timescale 1ns/1ps
module irq_casc_router_bench;
  localparam int A_EN0 = 0, A_EN1 = 1, A_CLS0 = 2, A_CLS1 = 3, A_PEND0 = 4, A_PEND1 = 5;
  localparam int A_IRQID = 6, A_FIQID = 7, A_ROUTE = 8, A_CORE = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] line_i = '0;
  logic [7:0]  local_i = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  core_irq_o, core_fiq_o;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_casc_router u_irq_casc_router (
    .clk(clk), .rst(rst), .line_i(line_i), .local_i(local_i), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .core_irq_o(core_irq_o), .core_fiq_o(core_fiq_o));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 5'(a); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 5'(a);
    step();
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 core_irq", {28'd0, core_irq_o}, 32'd0);
    chk("R1 core_fiq", {28'd0, core_fiq_o}, 32'd0);
    rd(A_EN0, d);   chk("R1 enable word0", d, 32'd0);
    rd(A_EN1, d);   chk("R1 enable word1", d, 32'd0);
    rd(A_CLS1, d);  chk("R1 class word1", d, 32'd0);
    rd(A_ROUTE, d); chk("R1 target", d, 32'd0);
    rd(A_IRQID, d); chk("R8 no irq source", d, 32'd0);
  endtask

  task automatic t_mask_and_latency();
    logic [31:0] d;
    line_i[5] = 1'b1;
    step(); step();
    chk("R2 disabled line no irq", {28'd0, core_irq_o}, 32'd0);
    rd(A_PEND0, d); chk("R2 disabled line not pending", d, 32'd0);
    wr(A_EN0, 32'h20);
    chk("R9 irq not yet at write edge", {28'd0, core_irq_o}, 32'd0);
    step();
    chk("R9 irq one cycle after write", {28'd0, core_irq_o}, 32'h1);
    rd(A_PEND0, d); chk("R2 pending word0", d, 32'h20);
  endtask

  task automatic t_level_drop();
    logic [31:0] d;
    line_i[5] = 1'b0;
    chk("R3 output held before edge", {28'd0, core_irq_o}, 32'h1);
    step();
    chk("R3 output falls after drop", {28'd0, core_irq_o}, 32'd0);
    rd(A_PEND0, d); chk("R3 pending cleared", d, 32'd0);
  endtask

  task automatic t_fiq_class();
    logic [31:0] d;
    wr(A_EN1, 32'h100);
    wr(A_CLS1, 32'h100);
    line_i[40] = 1'b1;
    step();
    chk("R4 fiq class on core0", {28'd0, core_fiq_o}, 32'h1);
    chk("R4 fiq class not irq", {28'd0, core_irq_o}, 32'd0);
    rd(A_PEND1, d); chk("R2 pending word1", d, 32'h100);
    wr(A_CLS1, 32'h0);
    step();
    chk("R4 reclassed to irq", {28'd0, core_irq_o}, 32'h1);
    chk("R4 reclassed not fiq", {28'd0, core_fiq_o}, 32'd0);
  endtask

  task automatic t_route_local();
    logic [31:0] d;
    wr(A_ROUTE, 32'h0000_0302);
    wr(A_EN0, 32'h20);
    wr(A_CLS1, 32'h100);
    line_i[5] = 1'b1;
    step();
    chk("R5 irq only to core2", {28'd0, core_irq_o}, 32'h4);
    chk("R6 fiq only to core3", {28'd0, core_fiq_o}, 32'h8);
    rd(A_ROUTE, d); chk("R6 target readback", d, 32'h0000_0302);
    local_i = 8'b0000_1000;
    step();
    chk("R7 local on core1 only", {28'd0, core_irq_o}, 32'h6);
    chk("R7 local no fiq", {28'd0, core_fiq_o}, 32'h8);
    rd(A_CORE + 1, d); chk("R10 core1 status", d, 32'h8);
    rd(A_CORE + 2, d); chk("R10 core2 status", d, 32'h1);
    rd(A_CORE + 3, d); chk("R10 core3 status", d, 32'h2);
    rd(A_CORE + 0, d); chk("R10 core0 status", d, 32'h0);
    local_i = '0;
    step();
    chk("R7 local released", {28'd0, core_irq_o}, 32'h4);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(A_EN0, 32'h0000_0428);
    wr(A_EN1, 32'h8004_0100);
    wr(A_CLS1, 32'h8000_0100);
    line_i[3] = 1'b1; line_i[10] = 1'b1; line_i[50] = 1'b1; line_i[63] = 1'b1;
    rd(A_IRQID, d); chk("R8 lowest irq source", d, 32'h8000_0003);
    rd(A_FIQID, d); chk("R8 lowest fiq source", d, 32'h8000_0028);
    rd(A_PEND1, d); chk("R2 pending word1 mixed", d, 32'h8004_0100);
    line_i[3] = 1'b0; line_i[40] = 1'b0;
    rd(A_IRQID, d); chk("R8 next irq source", d, 32'h8000_0005);
    rd(A_FIQID, d); chk("R8 fiq across word", d, 32'h8000_003f);
    line_i = '0;
    rd(A_IRQID, d); chk("R8 irq source empty", d, 32'd0);
    step();
    chk("R3 all outputs quiet", {24'd0, core_irq_o, core_fiq_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    t_reset();
    t_mask_and_latency();
    t_level_drop();
    t_fiq_class();
    t_route_local();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule